// File: doc/BRIEF.md
# Sector Buffer Flow Controller

This block sits beside a sector-organised circular data buffer that lies between a host port and a disk port. It does not hold the data. It keeps one slot pointer for each side and a count of the full sectors in the buffer. From that count it drives a ready signal to each side, so that the producing side stalls when the buffer is full and the consuming side stalls when it is empty. It also keeps a sector counter that tracks disk-side progress through a command.

A configuration write selects the transfer direction and loads the sector counter with the command's length. The write leaves the pointers and the occupancy alone. Because of this, host data from earlier write commands stays queued, and a new command picks up at the slot after the last one written. A synchronous clear flushes the pointers, the occupancy and the counter, and keeps the configured direction. Each side reports a finished sector by pulsing its commit input for one cycle. A commit counts only while that side's ready signal is high.

Top module: `sector_flow_ctrl`

## Requirements
- R1: After reset, both pointers and the occupancy are 0, empty is 1, full is 0, the sector count is 0, done is 1 and the direction is host-to-disk (`cur_dir` = 0).
- R2: An accepted producer commit raises occupancy by one. An accepted consumer commit lowers it by one. When both happen in the same cycle, occupancy does not change. Full is 1 exactly when occupancy is 16, empty is 1 exactly when it is 0, and occupancy never exceeds 16.
- R3: `host_rdy` equals occupancy < 16 when `cur_dir` = 0 (the host produces). It equals occupancy > 0 when `cur_dir` = 1 (the host consumes). It drops in the cycle after the commit that brings occupancy to 16.
- R4: `disk_rdy` requires a nonzero sector count. Given that, it equals occupancy > 0 when `cur_dir` = 0 and occupancy < 16 when `cur_dir` = 1.
- R5: A commit on a side whose ready signal is low is ignored. That side's pointer, the occupancy and the sector count stay as they were.
- R6: Each pointer advances by one, modulo 16, on an accepted commit from its own side. The producer pointer minus the consumer pointer, modulo 16, equals occupancy modulo 16.
- R7: A configuration write sets `cur_dir` and loads the sector count from `cfg_len` on the next edge. It leaves both pointers and the occupancy unchanged, so data queued by earlier write commands is kept.
- R8: The sector count drops by one on each accepted disk commit. `done` is 1 exactly when the count is 0.
- R9: `clr` zeroes both pointers, the occupancy and the sector count on the next edge, and leaves `cur_dir` unchanged. A configuration write in the same cycle still loads the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous flush of pointers, occupancy and count |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dir | input | 1 | Direction to write: 0 = host to disk, 1 = disk to host |
| cfg_len | input | 8 | Transfer length in sectors |
| host_commit | input | 1 | Host side finished one sector |
| disk_commit | input | 1 | Disk side finished one sector |
| host_rdy | output | 1 | Host side may move a sector |
| disk_rdy | output | 1 | Disk side may move a sector |
| host_ptr | output | 4 | Host slot index |
| disk_ptr | output | 4 | Disk slot index |
| occupancy | output | 5 | Full sectors held |
| full | output | 1 | Occupancy at capacity |
| empty | output | 1 | Occupancy zero |
| sec_cnt | output | 8 | Sectors left in the disk command |
| done | output | 1 | Sector count is zero |
| cur_dir | output | 1 | Configured direction |

## Verification
On every cycle the assertions check three things: that occupancy stays within capacity, and that each single-sided commit changes it by exactly one; that the gap between the pointers agrees with the occupancy; and that a commit refused by a low ready signal moves nothing, with the counter staying at zero once it is done. Some behaviour only the bench scenarios can show, because it needs a sequence of commands. That covers when each ready signal falls and rises as the buffer fills and drains, pointer positions kept across queued write commands, the disk side stopping when the count runs out while data is still queued, and the direction surviving a flush.

// File: rtl/sbfc_pkg.sv
package sbfc_pkg;

    typedef enum logic {
        DIR_H2D = 1'b0,
        DIR_D2H = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic inc;
        logic dec;
    } occ_step_t;

    function automatic int unsigned ring_next(int unsigned cur, int unsigned slots);
        return (cur + 1 == slots) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/sbfc_ring_ptr.sv
module sbfc_ring_ptr
    import sbfc_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int PTR_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            ptr <= '0;
        else if (adv)
            ptr <= PTR_W'(ring_next(int'(ptr), SLOTS));
    end
endmodule

// File: rtl/sbfc_occupancy.sv
module sbfc_occupancy
    import sbfc_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int OCC_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  occ_step_t        step,
    output logic [OCC_W-1:0] occ,
    output logic             full,
    output logic             empty
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            occ <= '0;
        else if (step.inc && !step.dec)
            occ <= occ + 1'b1;
        else if (step.dec && !step.inc)
            occ <= occ - 1'b1;
    end

    assign full  = (occ == OCC_W'(SLOTS));
    assign empty = (occ == '0);

    assert_occ_bound_R2: assert property (@(posedge clk) disable iff (rst)
        int'(occ) <= SLOTS);

    assert_occ_inc_R2: assert property (@(posedge clk) disable iff (rst)
        (step.inc && !step.dec && !clr) |=> (int'(occ) == int'($past(occ)) + 1));

    assert_occ_dec_R2: assert property (@(posedge clk) disable iff (rst)
        (step.dec && !step.inc && !clr) |=> (int'(occ) + 1 == int'($past(occ))));
endmodule

// File: rtl/sbfc_sector_count.sv
module sbfc_sector_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= len;
        else if (clr)
            cnt <= '0;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    assert_cnt_stays_done_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> done);

    assert_cnt_step_R8: assert property (@(posedge clk) disable iff (rst)
        (dec && !done && !load && !clr) |=> (int'(cnt) + 1 == int'($past(cnt))));
endmodule

// File: rtl/sector_flow_ctrl.sv
module sector_flow_ctrl
    import sbfc_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int CNT_W = 8,
    parameter int PTR_W = $clog2(SLOTS),
    parameter int OCC_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cfg_we,
    input  logic             cfg_dir,
    input  logic [CNT_W-1:0] cfg_len,
    input  logic             host_commit,
    input  logic             disk_commit,
    output logic             host_rdy,
    output logic             disk_rdy,
    output logic [PTR_W-1:0] host_ptr,
    output logic [PTR_W-1:0] disk_ptr,
    output logic [OCC_W-1:0] occupancy,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] sec_cnt,
    output logic             done,
    output logic             cur_dir
);
    localparam int NSIDE = 2;

    xfer_dir_e  dir_q;
    occ_step_t  step;
    logic       host_acc, disk_acc;
    logic [NSIDE-1:0]            side_adv;
    logic [NSIDE-1:0][PTR_W-1:0] side_ptr;

    always_ff @(posedge clk) begin
        if (rst)
            dir_q <= DIR_H2D;
        else if (cfg_we)
            dir_q <= xfer_dir_e'(cfg_dir);
    end
    assign cur_dir = dir_q;

    always_comb begin
        if (dir_q == DIR_H2D) begin
            host_rdy = !full;
            disk_rdy = !empty && !done;
        end else begin
            host_rdy = !empty;
            disk_rdy = !full && !done;
        end
        host_acc = host_commit && host_rdy;
        disk_acc = disk_commit && disk_rdy;
        step.inc = (dir_q == DIR_H2D) ? host_acc : disk_acc;
        step.dec = (dir_q == DIR_H2D) ? disk_acc : host_acc;
    end

    assign side_adv = {disk_acc, host_acc};

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        sbfc_ring_ptr #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_ptr (
            .clk (clk),
            .rst (rst),
            .clr (clr),
            .adv (side_adv[s]),
            .ptr (side_ptr[s])
        );
    end
    assign host_ptr = side_ptr[0];
    assign disk_ptr = side_ptr[1];

    sbfc_occupancy #(.SLOTS(SLOTS), .OCC_W(OCC_W)) u_occ (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .step  (step),
        .occ   (occupancy),
        .full  (full),
        .empty (empty)
    );

    sbfc_sector_count #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .load (cfg_we),
        .len  (cfg_len),
        .dec  (disk_acc),
        .cnt  (sec_cnt),
        .done (done)
    );

    // Pointer gap follows occupancy; direction is expected to change only with an empty buffer.
    assert_ptr_gap_R6: assert property (@(posedge clk) disable iff (rst)
        ((dir_q == DIR_H2D)
            ? ((int'(host_ptr) + SLOTS - int'(disk_ptr)) % SLOTS)
            : ((int'(disk_ptr) + SLOTS - int'(host_ptr)) % SLOTS))
        == (int'(occupancy) % SLOTS));

    assert_host_refused_R5: assert property (@(posedge clk) disable iff (rst)
        (host_commit && !host_rdy && !clr) |=> $stable(host_ptr));

    assert_disk_refused_R5: assert property (@(posedge clk) disable iff (rst)
        (disk_commit && !disk_rdy && !clr && !cfg_we) |=> ($stable(disk_ptr) && $stable(sec_cnt)));
endmodule

// File: tb/sector_flow_ctrl_tb_top.sv
module sector_flow_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0, cfg_we = 1'b0, cfg_dir = 1'b0;
    logic [7:0] cfg_len = '0;
    logic       host_commit = 1'b0, disk_commit = 1'b0;
    logic       host_rdy, disk_rdy, full, empty, done, cur_dir;
    logic [3:0] host_ptr, disk_ptr;
    logic [4:0] occupancy;
    logic [7:0] sec_cnt;

    always #4 clk = ~clk;

    sector_flow_ctrl dut_i (
        .clk(clk), .rst(rst), .clr(clr), .cfg_we(cfg_we), .cfg_dir(cfg_dir),
        .cfg_len(cfg_len), .host_commit(host_commit), .disk_commit(disk_commit),
        .host_rdy(host_rdy), .disk_rdy(disk_rdy), .host_ptr(host_ptr),
        .disk_ptr(disk_ptr), .occupancy(occupancy), .full(full), .empty(empty),
        .sec_cnt(sec_cnt), .done(done), .cur_dir(cur_dir)
    );

    int compared = 0;
    int mismatched = 0;
    int m_occ = 0, m_hp = 0, m_dp = 0, m_cnt = 0, m_dir = 0;

    task automatic check_eq(string req, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int m_host_rdy();
        return (m_dir == 0) ? int'(m_occ < 16) : int'(m_occ > 0);
    endfunction

    function automatic int m_disk_rdy();
        if (m_cnt == 0) return 0;
        return (m_dir == 0) ? int'(m_occ > 0) : int'(m_occ < 16);
    endfunction

    task automatic compare_all();
        check_eq("R2", "occupancy", int'(occupancy), m_occ);
        check_eq("R2", "full", int'(full), int'(m_occ == 16));
        check_eq("R2", "empty", int'(empty), int'(m_occ == 0));
        check_eq("R3", "host_rdy", int'(host_rdy), m_host_rdy());
        check_eq("R4", "disk_rdy", int'(disk_rdy), m_disk_rdy());
        check_eq("R6", "host_ptr", int'(host_ptr), m_hp);
        check_eq("R6", "disk_ptr", int'(disk_ptr), m_dp);
        check_eq("R8", "sec_cnt", int'(sec_cnt), m_cnt);
        check_eq("R8", "done", int'(done), int'(m_cnt == 0));
        check_eq("R7", "cur_dir", int'(cur_dir), m_dir);
    endtask

    // Called at a falling edge: compare, drive, advance model, wait one cycle.
    task automatic step(bit hc, bit dc, bit c, bit we, bit d, int len);
        int hacc, dacc, prod, cons;
        compare_all();
        host_commit = hc; disk_commit = dc; clr = c;
        cfg_we = we; cfg_dir = d; cfg_len = 8'(len);
        hacc = int'(hc) & m_host_rdy();
        dacc = int'(dc) & m_disk_rdy();
        if (c) begin
            m_hp = 0; m_dp = 0; m_occ = 0; m_cnt = 0;
        end else begin
            prod = (m_dir == 0) ? hacc : dacc;
            cons = (m_dir == 0) ? dacc : hacc;
            if (hacc != 0) m_hp = (m_hp + 1) % 16;
            if (dacc != 0) m_dp = (m_dp + 1) % 16;
            m_occ = m_occ + prod - cons;
            if (dacc != 0 && m_cnt > 0) m_cnt = m_cnt - 1;
        end
        if (we) begin
            m_dir = int'(d);
            m_cnt = len;
        end
        @(negedge clk);
        host_commit = 0; disk_commit = 0; clr = 0; cfg_we = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        check_eq("R1", "occupancy", int'(occupancy), 0);
        check_eq("R1", "empty", int'(empty), 1);
        check_eq("R1", "full", int'(full), 0);
        check_eq("R1", "done", int'(done), 1);
        check_eq("R1", "host_ptr", int'(host_ptr), 0);
        check_eq("R1", "cur_dir", int'(cur_dir), 0);
        rst = 0;
        idle(2);

        // R3/R5: host fills a write-direction buffer, extra commits refused
        step(0, 0, 0, 1, 0, 40);
        for (int i = 0; i < 20; i++) step(1, 0, 0, 0, 0, 0);
        check_eq("R3", "host_rdy at full", int'(host_rdy), 0);
        check_eq("R5", "host_ptr after refused commits", int'(host_ptr), 0);

        // R4: disk drains until empty, then stalls
        for (int i = 0; i < 20; i++) step(0, 1, 0, 0, 0, 0);
        check_eq("R4", "disk_rdy at empty", int'(disk_rdy), 0);
        check_eq("R8", "sec_cnt after 16 sectors", int'(sec_cnt), 24);

        // R7: queued write commands keep earlier data
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 3);
        check_eq("R7", "occupancy kept over cfg write", int'(occupancy), 5);
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0);
        // R8: count runs out with data still queued
        for (int i = 0; i < 6; i++) step(0, 1, 0, 0, 0, 0);
        check_eq("R8", "done after 3 sectors", int'(done), 1);
        check_eq("R4", "disk_rdy with count zero", int'(disk_rdy), 0);
        check_eq("R5", "occupancy after refused disk", int'(occupancy), 6);
        step(0, 0, 0, 1, 0, 10);
        for (int i = 0; i < 8; i++) step(0, 1, 0, 0, 0, 0);

        // R2/R6: mixed traffic in write direction
        step(0, 0, 0, 1, 0, 250);
        for (int i = 0; i < 400; i++)
            step(bit'($urandom_range(0, 99) < 55), bit'($urandom_range(0, 99) < 45), 0, 0, 0, 0);

        // R9: flush keeps direction
        step(1, 1, 1, 0, 0, 0);
        check_eq("R9", "occupancy after clr", int'(occupancy), 0);
        check_eq("R9", "cur_dir after clr", int'(cur_dir), 0);

        // read direction: disk produces
        step(0, 0, 0, 1, 1, 30);
        for (int i = 0; i < 20; i++) step(0, 1, 0, 0, 0, 0);
        check_eq("R4", "disk_rdy at full read", int'(disk_rdy), 0);
        check_eq("R3", "host_rdy with data read", int'(host_rdy), 1);
        step(0, 0, 0, 1, 1, 200);
        for (int i = 0; i < 400; i++)
            step(bit'($urandom_range(0, 99) < 45), bit'($urandom_range(0, 99) < 55), 0, 0, 0, 0);

        // R9: clr together with a configuration write
        step(0, 0, 1, 1, 1, 7);
        check_eq("R9", "sec_cnt load wins over clr", int'(sec_cnt), 7);
        check_eq("R9", "disk_ptr after clr", int'(disk_ptr), 0);
        idle(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule